// File: doc/BRIEF.md
# Register Alias Table with Tag Update

This block tracks, for every architectural floating-point register, which in-flight operation will produce that register's next value. Each register has one entry. The entry holds the producer's station tag, or zero when no pending operation targets the register. An issue stage uses the block to rename an instruction. The two source specifiers are translated into either "ready, read the register file" (tag zero) or the tag to wait on. In the same cycle, the destination entry is overwritten with the tag of the newly allocated station.

A result broadcast input carries a completing station's tag and its value. Any entry still holding that tag returns to empty on the next clock edge. An entry that has since been renamed to a younger producer keeps the younger tag, so the latest writer always wins. A source lookup that hits the tag being broadcast in the same cycle reports ready and hands back the broadcast value. The consumer therefore never waits on a result that is on the bus at that moment.

Top module: `rename_alias_table`

## Requirements
- R1: Reset (active-low, asynchronous) empties every entry, so a lookup of any register returns tag 0 with the bypass flag low.
- R2: Each source port combinationally returns the tag held by the register it names, whether or not an issue is requested. A nonzero tag means the value is pending. Tag 0 means the register file holds the value, and in that case the bypass flag and bypass data are 0.
- R3: An issue (issue valid high, tag nonzero) writes its tag into the destination register's entry, visible on lookups from the next cycle.
- R4: A broadcast with a nonzero tag empties, at the next edge, every entry whose held tag equals it.
- R5: A broadcast leaves every entry holding a different tag unchanged, so a register renamed after the broadcasting producer keeps its newer tag.
- R6: A lookup of a register whose held tag equals the tag of a valid, nonzero broadcast in the same cycle returns tag 0, bypass flag 1 and bypass data equal to the broadcast data.
- R7: When an instruction's destination equals one of its sources, that source lookup returns the mapping held before this issue.
- R8: When an issue and a matching broadcast target the same entry in one cycle, the entry takes the issue's tag.
- R9: An issue with issue valid low or with tag 0 changes no entry. A broadcast with tag 0 changes no entry and never raises the bypass flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is being renamed this cycle |
| iss_dst | input | IDX_W | Destination register specifier |
| iss_tag | input | TAG_W | Station tag allocated to the instruction (nonzero) |
| src_a_idx | input | IDX_W | First source register specifier |
| src_b_idx | input | IDX_W | Second source register specifier |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcasting station |
| bc_data | input | DATA_W | Broadcast result value |
| src_a_tag | output | TAG_W | Producer tag for source A, 0 when ready |
| src_a_byp | output | 1 | Source A is satisfied by the broadcast this cycle |
| src_a_data | output | DATA_W | Broadcast value for source A when bypassed, else 0 |
| src_b_tag | output | TAG_W | Producer tag for source B, 0 when ready |
| src_b_byp | output | 1 | Source B is satisfied by the broadcast this cycle |
| src_b_data | output | DATA_W | Broadcast value for source B when bypassed, else 0 |

## Verification
The bench aims at the stale broadcast. If a design cleared entries by register number rather than by held tag, a renamed register would lose its younger producer and later readers would go ahead with the wrong value. It also covers an instruction that reads its own destination, where a design that looked up after the write would wait on itself forever. Two further corners are an issue colliding with a matching broadcast, which a wrong priority would leave empty, and a same-cycle lookup of the broadcast tag, which a design without bypass would report as still pending. Zero tags on either port are driven to show that neither can clear, rename or bypass anything.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int RAT_NREGS  = 32;
  localparam int RAT_TAG_W  = 4;
  localparam int RAT_DATA_W = 64;

  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_CLEAR  = 2'd1,
    UPD_RENAME = 2'd2
  } upd_e;

  // Rename beats clear (R8); clear beats hold.
  function automatic upd_e pick_update(input logic wr_hit, input logic clr_hit);
    if (wr_hit)       return UPD_RENAME;
    else if (clr_hit) return UPD_CLEAR;
    else              return UPD_HOLD;
  endfunction
endpackage

// File: rtl/rat_entry.sv
module rat_entry
  import rat_pkg::*;
#(
  parameter int TAG_W = RAT_TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  output logic [TAG_W-1:0] held_q,
  output logic             clr_hit
);
  upd_e upd;

  assign clr_hit = bc_valid && (bc_tag != '0) && (held_q == bc_tag);
  assign upd     = pick_update(wr_hit, clr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else begin
      unique case (upd)
        UPD_RENAME: held_q <= wr_tag;
        UPD_CLEAR:  held_q <= '0;
        default:    held_q <= held_q;
      endcase
    end
  end
endmodule

// File: rtl/rat_lookup.sv
module rat_lookup
  import rat_pkg::*;
#(
  parameter int NREGS  = RAT_NREGS,
  parameter int TAG_W  = RAT_TAG_W,
  parameter int DATA_W = RAT_DATA_W,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][TAG_W-1:0] map_q,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        bc_valid,
  input  logic [TAG_W-1:0]            bc_tag,
  input  logic [DATA_W-1:0]           bc_data,
  output logic [TAG_W-1:0]            tag_o,
  output logic                        byp_o,
  output logic [DATA_W-1:0]           data_o
);
  logic [TAG_W-1:0] held;

  function automatic logic bc_catches(input logic v, input logic [TAG_W-1:0] bt,
                                      input logic [TAG_W-1:0] h);
    return v && (bt != '0) && (h == bt);
  endfunction

  always_comb begin
    held   = map_q[idx];
    byp_o  = bc_catches(bc_valid, bc_tag, held);
    tag_o  = byp_o ? '0 : held;
    data_o = byp_o ? bc_data : '0;
  end
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table
  import rat_pkg::*;
#(
  parameter int NREGS  = RAT_NREGS,
  parameter int TAG_W  = RAT_TAG_W,
  parameter int DATA_W = RAT_DATA_W,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic              src_a_byp,
  output logic [DATA_W-1:0] src_a_data,
  output logic [TAG_W-1:0]  src_b_tag,
  output logic              src_b_byp,
  output logic [DATA_W-1:0] src_b_data
);
  logic [NREGS-1:0][TAG_W-1:0] map_q;
  logic [NREGS-1:0]            wr_hit;
  logic [NREGS-1:0]            clr_hit;
  logic                        iss_live;

  assign iss_live = iss_valid && (iss_tag != '0);

  for (genvar i = 0; i < NREGS; i++) begin : g_entry
    assign wr_hit[i] = iss_live && (iss_dst == IDX_W'(i));
    rat_entry #(.TAG_W(TAG_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit[i]),
      .wr_tag  (iss_tag),
      .bc_valid(bc_valid),
      .bc_tag  (bc_tag),
      .held_q  (map_q[i]),
      .clr_hit (clr_hit[i])
    );
  end

  // Lookups read the registered table, i.e. the pre-issue mapping (R7).
  rat_lookup #(.NREGS(NREGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_look_a (
    .map_q(map_q), .idx(src_a_idx), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data), .tag_o(src_a_tag), .byp_o(src_a_byp), .data_o(src_a_data)
  );
  rat_lookup #(.NREGS(NREGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_look_b (
    .map_q(map_q), .idx(src_b_idx), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data), .tag_o(src_b_tag), .byp_o(src_b_byp), .data_o(src_b_data)
  );
endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
  parameter int NREGS  = 32,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(NREGS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        iss_valid,
  input logic [TAG_W-1:0]            iss_tag,
  input logic                        bc_valid,
  input logic [TAG_W-1:0]            bc_tag,
  input logic [DATA_W-1:0]           bc_data,
  input logic [NREGS-1:0][TAG_W-1:0] map_q,
  input logic [NREGS-1:0]            wr_hit,
  input logic [NREGS-1:0]            clr_hit,
  input logic [TAG_W-1:0]            src_a_tag,
  input logic                        src_a_byp,
  input logic [DATA_W-1:0]           src_a_data
);
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid || iss_tag == '0) |-> (wr_hit == '0));

  a_r9_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  a_r6_bypass_value: assert property (@(posedge clk) disable iff (!rst_n)
    src_a_byp |-> (src_a_tag == '0 && src_a_data == bc_data && bc_valid));

  a_r2_no_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
    !src_a_byp |-> (src_a_data == '0));

  for (genvar i = 0; i < NREGS; i++) begin : g_ent
    a_r3_rename: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> (map_q[i] == $past(iss_tag)));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && !wr_hit[i]) |=> (map_q[i] == '0));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[i] && !(bc_valid && bc_tag != '0 && map_q[i] == bc_tag))
        |=> $stable(map_q[i]));

    a_r8_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[i] && clr_hit[i]) |=> (map_q[i] != '0));
  end
endmodule

bind rename_alias_table rat_checker #(
  .NREGS(NREGS), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tag(iss_tag),
  .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
  .map_q(map_q), .wr_hit(wr_hit), .clr_hit(clr_hit),
  .src_a_tag(src_a_tag), .src_a_byp(src_a_byp), .src_a_data(src_a_data)
);

// File: tb/sim_rename_alias_table.sv
module sim_rename_alias_table;
  localparam int NREGS  = 32;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [IDX_W-1:0] iss_dst = '0, src_a_idx = '0, src_b_idx = '0;
  logic [TAG_W-1:0] iss_tag = '0, bc_tag = '0;
  logic bc_valid = 1'b0;
  logic [DATA_W-1:0] bc_data = '0;
  logic [TAG_W-1:0] src_a_tag, src_b_tag;
  logic src_a_byp, src_b_byp;
  logic [DATA_W-1:0] src_a_data, src_b_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rename_alias_table u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_tag(iss_tag), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .src_a_tag(src_a_tag), .src_a_byp(src_a_byp), .src_a_data(src_a_data),
    .src_b_tag(src_b_tag), .src_b_byp(src_b_byp), .src_b_data(src_b_data)
  );

  typedef struct packed {
    logic       iv;
    logic [4:0] dst;
    logic [3:0] tg;
    logic [4:0] sa;
    logic [4:0] sb;
    logic       bv;
    logic [3:0] bt;
    logic [15:0] bd;
    logic [3:0] ea;
    logic       pa;
    logic [3:0] eb;
    logic       pb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  //                   iv dst tg  sa sb bv bt bd        ea pa eb pb req
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd2, 4'd1, 5'd0, 5'd0, 1'b0, 4'd0, 16'h0000, 4'd0, 1'b0, 4'd0, 1'b0, 4'd3}, // R3 F2->1
    '{1'b1, 5'd0, 4'd9, 5'd2, 5'd4, 1'b0, 4'd0, 16'h0000, 4'd1, 1'b0, 4'd0, 1'b0, 4'd3}, // R3 F0->9, src F2=1
    '{1'b0, 5'd0, 4'd0, 5'd0, 5'd2, 1'b0, 4'd0, 16'h0000, 4'd9, 1'b0, 4'd1, 1'b0, 4'd2}, // R2
    '{1'b1, 5'd6, 4'd3, 5'd6, 5'd6, 1'b0, 4'd0, 16'h0000, 4'd0, 1'b0, 4'd0, 1'b0, 4'd7}, // R7 own dst
    '{1'b1, 5'd6, 4'd5, 5'd6, 5'd2, 1'b0, 4'd0, 16'h0000, 4'd3, 1'b0, 4'd1, 1'b0, 4'd7}, // R7 pre-map 3
    '{1'b0, 5'd0, 4'd0, 5'd6, 5'd0, 1'b1, 4'd3, 16'h1234, 4'd5, 1'b0, 4'd9, 1'b0, 4'd5}, // R5 stale bc
    '{1'b0, 5'd0, 4'd0, 5'd6, 5'd2, 1'b0, 4'd0, 16'h0000, 4'd5, 1'b0, 4'd1, 1'b0, 4'd5}, // R5 kept
    '{1'b0, 5'd0, 4'd0, 5'd2, 5'd0, 1'b1, 4'd1, 16'hBEEF, 4'd0, 1'b1, 4'd9, 1'b0, 4'd6}, // R6 bypass
    '{1'b0, 5'd0, 4'd0, 5'd2, 5'd0, 1'b0, 4'd0, 16'h0000, 4'd0, 1'b0, 4'd9, 1'b0, 4'd4}, // R4 cleared
    '{1'b1, 5'd0, 4'd7, 5'd0, 5'd4, 1'b1, 4'd9, 16'h0042, 4'd0, 1'b1, 4'd0, 1'b0, 4'd8}, // R8 collide
    '{1'b0, 5'd0, 4'd0, 5'd0, 5'd6, 1'b0, 4'd0, 16'h0000, 4'd7, 1'b0, 4'd5, 1'b0, 4'd8}, // R8 issue won
    '{1'b0, 5'd6, 4'd2, 5'd6, 5'd6, 1'b0, 4'd0, 16'h0000, 4'd5, 1'b0, 4'd5, 1'b0, 4'd9}, // R9 valid low
    '{1'b0, 5'd0, 4'd0, 5'd6, 5'd8, 1'b0, 4'd0, 16'h0000, 4'd5, 1'b0, 4'd0, 1'b0, 4'd9}, // R9 unchanged
    '{1'b1, 5'd6, 4'd0, 5'd6, 5'd6, 1'b0, 4'd0, 16'h0000, 4'd5, 1'b0, 4'd5, 1'b0, 4'd9}, // R9 zero tag
    '{1'b0, 5'd0, 4'd0, 5'd6, 5'd0, 1'b0, 4'd0, 16'h0000, 4'd5, 1'b0, 4'd7, 1'b0, 4'd9}, // R9 unchanged
    '{1'b0, 5'd0, 4'd0, 5'd0, 5'd6, 1'b1, 4'd0, 16'h7777, 4'd7, 1'b0, 4'd5, 1'b0, 4'd9}, // R9 zero bc
    '{1'b0, 5'd0, 4'd0, 5'd6, 5'd6, 1'b1, 4'd5, 16'h5A5A, 4'd0, 1'b1, 4'd0, 1'b1, 4'd6}, // R6 both ports
    '{1'b0, 5'd0, 4'd0, 5'd6, 5'd0, 1'b0, 4'd0, 16'h0000, 4'd0, 1'b0, 4'd7, 1'b0, 4'd4}  // R4 cleared
  };

  task automatic check_port(input string port, input int req,
                            input logic [TAG_W-1:0] at, input logic ab, input logic [DATA_W-1:0] ad,
                            input logic [TAG_W-1:0] et, input logic eb, input logic [DATA_W-1:0] ed);
    n_checks++;
    if (at !== et || ab !== eb || ad !== ed) begin
      n_fail++;
      $display("FAIL R%0d port %s: tag=%0d byp=%0b data=%h, expected tag=%0d byp=%0b data=%h",
               req, port, at, ab, ad, et, eb, ed);
    end
  endtask

  task automatic idle_inputs();
    iss_valid = 1'b0; iss_dst = '0; iss_tag = '0;
    bc_valid = 1'b0; bc_tag = '0; bc_data = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every register empty after reset
    for (int i = 0; i < NREGS; i++) begin
      @(negedge clk);
      src_a_idx = IDX_W'(i);
      src_b_idx = IDX_W'(NREGS - 1 - i);
      #5;
      check_port("a", 1, src_a_tag, src_a_byp, src_a_data, '0, 1'b0, '0);
      check_port("b", 1, src_b_tag, src_b_byp, src_b_data, '0, 1'b0, '0);
    end

    // Vector table: inputs at negedge, outputs checked 5 ns later (before posedge)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      iss_valid = VECS[v].iv; iss_dst = VECS[v].dst; iss_tag = VECS[v].tg;
      src_a_idx = VECS[v].sa; src_b_idx = VECS[v].sb;
      bc_valid = VECS[v].bv; bc_tag = VECS[v].bt; bc_data = DATA_W'(VECS[v].bd);
      #5;
      check_port("a", int'(VECS[v].req), src_a_tag, src_a_byp, src_a_data,
                 VECS[v].ea, VECS[v].pa, VECS[v].pa ? DATA_W'(VECS[v].bd) : '0);
      check_port("b", int'(VECS[v].req), src_b_tag, src_b_byp, src_b_data,
                 VECS[v].eb, VECS[v].pb, VECS[v].pb ? DATA_W'(VECS[v].bd) : '0);
    end

    // R1: reset in mid-run clears live mappings (F0 holds 7 here)
    @(negedge clk);
    idle_inputs();
    src_a_idx = 5'd0; src_b_idx = 5'd6;
    #2;
    check_port("a", 2, src_a_tag, src_a_byp, src_a_data, 4'd7, 1'b0, '0);
    rst_n = 1'b0;
    #3;
    check_port("a", 1, src_a_tag, src_a_byp, src_a_data, '0, 1'b0, '0);
    check_port("b", 1, src_b_tag, src_b_byp, src_b_data, '0, 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 after reset: rename is accepted again
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = 5'd31; iss_tag = 4'd15;
    @(negedge clk);
    idle_inputs();
    src_a_idx = 5'd31;
    #5;
    check_port("a", 3, src_a_tag, src_a_byp, src_a_data, 4'd15, 1'b0, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule